// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block holds the two threshold offsets that a FIFO's status-flag comparators use. One offset sets how close to empty the almost-empty flag rises, and the other sets how close to full the almost-full flag rises. The FIFO has no separate configuration port. Software loads the offsets through the FIFO's own data input bus and reads them back through its data output bus. A load strobe turns ordinary write and read cycles into offset transfers.

Each offset is split into segments, and the segments move in a fixed rotation: almost-empty low part first, then its upper part or parts, then the almost-full parts in the same way. After the last segment the rotation returns to the start. The write side and the read side each keep their own segment pointer, in their own clock domain. Both pointers share one state machine design, with these states: `SEG_AE0`, `SEG_AE1`, `SEG_AE2`, `SEG_AF0`, `SEG_AF1` and `SEG_AF2`.

The bus mode is sampled while reset is held. In wide mode two transfers make one offset. One transition runs `SEG_AE0`→`SEG_AE1`→`SEG_AF0`→`SEG_AF1`→`SEG_AE0`. In narrow mode a third transfer is added for each offset. The rotation then runs `SEG_AE0`→`SEG_AE1`→`SEG_AE2`→`SEG_AF0`→`SEG_AF1`→`SEG_AF2`→`SEG_AE0`. A pointer steps only on a clock edge where the load strobe and the enable of its side are both high. In every other cycle the pointer stays in its state.

Top module: `ofs_loader`

## Requirements
- R1: While `rst` is high on a clock edge, the block resets. The write pointer goes to `SEG_AE0` and the almost-empty offset takes its default value (24'h00007F). The almost-full offset takes its default value (24'h0003F0). The read pointer goes to `SEG_AE0` and `q` goes to zero.
- R2: `narrow` is sampled only while `rst` is high (1 = narrow, 0 = wide). Changing it after reset has no effect on the segment rotation.
- R3: In wide mode, four write steps load the offsets in this order: almost-empty bits 15:0 from `din[15:0]`, almost-empty bits 23:16 from `din[7:0]`, almost-full bits 15:0, almost-full bits 23:16.
- R4: In narrow mode, six write steps load the offsets. For each offset the order is bits 7:0, then 15:8, then 23:16, each taken from `din[7:0]`. The almost-empty offset comes first.
- R5: The write pointer and both offsets change only on a `clk_w` edge where `ld` and `wen` are both high. `wen` without `ld`, or `ld` without `wen`, changes nothing.
- R6: After the last almost-full segment, the next step of either pointer returns it to `SEG_AE0`.
- R7: On a `clk_r` edge where `ld` and `ren` are both high, `q` takes the segment at the read pointer, and the read pointer then advances. The segment is zero-extended, with the same order and bit positions as in R3 and R4. In any other cycle `q` holds its value.
- R8: The read pointer moves independently of the write pointer.
- R9: Bits of `din` above the active segment width are ignored: above bit 15 in wide low segments, and above bit 7 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_w | input | 1 | Write-side clock |
| clk_r | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous master reset, active high; must span edges of both clocks |
| narrow | input | 1 | Bus mode, sampled during reset: 1 narrow, 0 wide |
| ld | input | 1 | Load strobe: selects offset transfers instead of FIFO traffic |
| wen | input | 1 | Write enable |
| ren | input | 1 | Read enable |
| din | input | 18 | Shared data input bus |
| q | output | 18 | Shared data output bus, offset segment on readback |
| ae_ofs | output | 24 | Almost-empty offset, to the flag comparator |
| af_ofs | output | 24 | Almost-full offset, to the flag comparator |

## Verification
The loader is driven with distinct segment values in wide mode. Because every segment value is different, a wrong order, a wrong bit position or a skipped step each shows up as a different wrong offset. The same loader is then driven in narrow mode, with the mode pin flipped right after reset. This separates a two-part rotation from a three-part rotation, and a mode captured in reset from a live one. Idle patterns (enable without strobe, strobe without enable) check that nothing moves. A single write after a complete rotation, paired with a single read, checks both the wrap and the independence of the two pointers. Stray high `din` bits check that unused bits are masked.

// File: rtl/ofs_loader_pkg.sv
package ofs_loader_pkg;
    typedef enum logic [2:0] {
        SEG_AE0 = 3'd0,
        SEG_AE1 = 3'd1,
        SEG_AE2 = 3'd2,
        SEG_AF0 = 3'd3,
        SEG_AF1 = 3'd4,
        SEG_AF2 = 3'd5
    } seg_e;
endpackage

// File: rtl/ofs_seg_fsm.sv
module ofs_seg_fsm
    import ofs_loader_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       narrow_i,
    input  logic       step,
    output seg_e       st,
    output logic       narrow_o,
    output logic       is_af,
    output logic [1:0] part
);
    seg_e nxt;
    logic narrow_q;

    // state register; mode captured only during reset
    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SEG_AE0;
            narrow_q <= narrow_i;
        end else if (step) begin
            st <= nxt;
        end
    end

    always_comb begin
        unique case (st)
            SEG_AE0: nxt = SEG_AE1;
            SEG_AE1: nxt = narrow_q ? SEG_AE2 : SEG_AF0;
            SEG_AE2: nxt = SEG_AF0;
            SEG_AF0: nxt = SEG_AF1;
            SEG_AF1: nxt = narrow_q ? SEG_AF2 : SEG_AE0;
            SEG_AF2: nxt = SEG_AE0;
            default: nxt = SEG_AE0;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        narrow_o = narrow_q;
        unique case (st)
            SEG_AE0: begin is_af = 1'b0; part = 2'd0; end
            SEG_AE1: begin is_af = 1'b0; part = 2'd1; end
            SEG_AE2: begin is_af = 1'b0; part = 2'd2; end
            SEG_AF0: begin is_af = 1'b1; part = 2'd0; end
            SEG_AF1: begin is_af = 1'b1; part = 2'd1; end
            SEG_AF2: begin is_af = 1'b1; part = 2'd2; end
            default: begin is_af = 1'b0; part = 2'd0; end
        endcase
    end
endmodule

// File: rtl/ofs_store.sv
module ofs_store #(
    parameter int OFS_W      = 24,
    parameter int BUS_W      = 18,
    parameter int WIDE_SEG   = 16,
    parameter int NARROW_SEG = 8,
    parameter logic [OFS_W-1:0] AE_DEF = 24'h00007F,
    parameter logic [OFS_W-1:0] AF_DEF = 24'h0003F0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             narrow,
    input  logic             is_af,
    input  logic [1:0]       part,
    input  logic [BUS_W-1:0] din,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs
);
    logic [OFS_W-1:0] upd;

    // merge the incoming segment into the selected offset
    always_comb begin
        int segw;
        int lo;
        int last;
        segw = narrow ? NARROW_SEG : WIDE_SEG;
        last = narrow ? 2 : 1;
        lo   = int'(part) * segw;
        upd  = is_af ? af_ofs : ae_ofs;
        for (int i = 0; i < OFS_W; i++) begin
            if (i >= lo && (i < lo + segw || int'(part) == last)
                && (i - lo) < BUS_W && (i - lo) < segw) begin
                upd[i] = din[i - lo];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ae_ofs <= AE_DEF;
            af_ofs <= AF_DEF;
        end else if (we) begin
            if (is_af) af_ofs <= upd;
            else       ae_ofs <= upd;
        end
    end
endmodule

// File: rtl/ofs_readback.sv
module ofs_readback #(
    parameter int OFS_W      = 24,
    parameter int BUS_W      = 18,
    parameter int WIDE_SEG   = 16,
    parameter int NARROW_SEG = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             re,
    input  logic             narrow,
    input  logic             is_af,
    input  logic [1:0]       part,
    input  logic [OFS_W-1:0] ae_ofs,
    input  logic [OFS_W-1:0] af_ofs,
    output logic [BUS_W-1:0] q
);
    logic [BUS_W-1:0] seg;

    always_comb begin
        int segw;
        int lo;
        logic [OFS_W-1:0] sel;
        segw = narrow ? NARROW_SEG : WIDE_SEG;
        lo   = int'(part) * segw;
        sel  = is_af ? af_ofs : ae_ofs;
        seg  = '0;
        for (int i = 0; i < BUS_W; i++) begin
            if (i < segw && (lo + i) < OFS_W) seg[i] = sel[lo + i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (re) q <= seg;
    end
endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
    import ofs_loader_pkg::*;
#(
    parameter int OFS_W      = 24,
    parameter int BUS_W      = 18,
    parameter int WIDE_SEG   = 16,
    parameter int NARROW_SEG = 8,
    parameter logic [OFS_W-1:0] AE_DEF = 24'h00007F,
    parameter logic [OFS_W-1:0] AF_DEF = 24'h0003F0
) (
    input  logic             clk_w,
    input  logic             clk_r,
    input  logic             rst,
    input  logic             narrow,
    input  logic             ld,
    input  logic             wen,
    input  logic             ren,
    input  logic [BUS_W-1:0] din,
    output logic [BUS_W-1:0] q,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs
);
    logic       wr_step, rd_step;
    seg_e       wr_st, rd_st;
    logic       wr_narrow, rd_narrow;
    logic       wr_af, rd_af;
    logic [1:0] wr_part, rd_part;

    assign wr_step = ld & wen;
    assign rd_step = ld & ren;

    ofs_seg_fsm u_wr_fsm (
        .clk(clk_w), .rst(rst), .narrow_i(narrow), .step(wr_step),
        .st(wr_st), .narrow_o(wr_narrow), .is_af(wr_af), .part(wr_part)
    );

    ofs_seg_fsm u_rd_fsm (
        .clk(clk_r), .rst(rst), .narrow_i(narrow), .step(rd_step),
        .st(rd_st), .narrow_o(rd_narrow), .is_af(rd_af), .part(rd_part)
    );

    ofs_store #(
        .OFS_W(OFS_W), .BUS_W(BUS_W), .WIDE_SEG(WIDE_SEG),
        .NARROW_SEG(NARROW_SEG), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)
    ) u_store (
        .clk(clk_w), .rst(rst), .we(wr_step), .narrow(wr_narrow),
        .is_af(wr_af), .part(wr_part), .din(din),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs)
    );

    ofs_readback #(
        .OFS_W(OFS_W), .BUS_W(BUS_W), .WIDE_SEG(WIDE_SEG),
        .NARROW_SEG(NARROW_SEG)
    ) u_rdbk (
        .clk(clk_r), .rst(rst), .re(rd_step), .narrow(rd_narrow),
        .is_af(rd_af), .part(rd_part), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
        .q(q)
    );
endmodule

// File: rtl/ofs_loader_chk.sv
module ofs_loader_chk
    import ofs_loader_pkg::*;
#(
    parameter int OFS_W = 24,
    parameter int BUS_W = 18,
    parameter logic [OFS_W-1:0] AE_DEF = 24'h00007F,
    parameter logic [OFS_W-1:0] AF_DEF = 24'h0003F0
) (
    input logic             clk_w,
    input logic             clk_r,
    input logic             rst,
    input logic             ld,
    input logic             wen,
    input logic             ren,
    input seg_e             wr_st,
    input seg_e             rd_st,
    input logic             wr_narrow,
    input logic [BUS_W-1:0] q,
    input logic [OFS_W-1:0] ae_ofs,
    input logic [OFS_W-1:0] af_ofs
);
    AST_RST_WR_DEF: assert property (@(posedge clk_w)
        rst |=> (ae_ofs == AE_DEF && af_ofs == AF_DEF && wr_st == SEG_AE0)); // R1
    AST_RST_RD_DEF: assert property (@(posedge clk_r)
        rst |=> (q == '0 && rd_st == SEG_AE0)); // R1
    AST_WIDE_NO_THIRD: assert property (@(posedge clk_w) disable iff (rst)
        !wr_narrow |-> (wr_st != SEG_AE2 && wr_st != SEG_AF2)); // R3
    AST_WR_IDLE_HOLD: assert property (@(posedge clk_w) disable iff (rst)
        !(ld && wen) |=> ($stable(wr_st) && $stable(ae_ofs) && $stable(af_ofs))); // R5
    AST_WR_WRAP: assert property (@(posedge clk_w) disable iff (rst)
        (ld && wen && (wr_st == SEG_AF2 || (wr_st == SEG_AF1 && !wr_narrow)))
        |=> wr_st == SEG_AE0); // R6
    AST_RD_IDLE_HOLD: assert property (@(posedge clk_r) disable iff (rst)
        !(ld && ren) |=> ($stable(q) && $stable(rd_st))); // R7
endmodule

bind ofs_loader ofs_loader_chk #(
    .OFS_W(OFS_W), .BUS_W(BUS_W), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)
) u_chk (
    .clk_w(clk_w), .clk_r(clk_r), .rst(rst), .ld(ld), .wen(wen), .ren(ren),
    .wr_st(wr_st), .rd_st(rd_st), .wr_narrow(wr_narrow), .q(q),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs)
);

// File: tb/ofs_loader_test.sv
module ofs_loader_test;
    localparam int CLK_PERIOD  = 10;
    localparam int RCLK_PERIOD = 14;

    logic        clk_w = 1'b0, clk_r = 1'b0;
    logic        rst = 1'b1, narrow = 1'b0, ld = 1'b0, wen = 1'b0, ren = 1'b0;
    logic [17:0] din = '0;
    logic [17:0] q;
    logic [23:0] ae_ofs, af_ofs;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2)  clk_w = ~clk_w;
    always #(RCLK_PERIOD/2) clk_r = ~clk_r;

    ofs_loader uut (
        .clk_w(clk_w), .clk_r(clk_r), .rst(rst), .narrow(narrow), .ld(ld),
        .wen(wen), .ren(ren), .din(din), .q(q), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic nm);
        @(negedge clk_w);
        rst = 1'b1; narrow = nm; ld = 1'b0; wen = 1'b0; ren = 1'b0;
        repeat (5) @(negedge clk_w);
        rst = 1'b0;
    endtask

    task automatic write_seg(input logic [17:0] d);
        @(negedge clk_w);
        ld = 1'b1; wen = 1'b1; din = d;
        @(negedge clk_w);
        ld = 1'b0; wen = 1'b0;
    endtask

    task automatic read_seg(input string req, input logic [17:0] exp);
        @(negedge clk_r);
        ld = 1'b1; ren = 1'b1;
        @(negedge clk_r);
        ld = 1'b0; ren = 1'b0;
        chk(req, {14'd0, q}, {14'd0, exp});
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        @(negedge clk_r);
        chk("R1 ae default", {8'd0, ae_ofs}, 32'h00007F);
        chk("R1 af default", {8'd0, af_ofs}, 32'h0003F0);
        chk("R1 q zero", {14'd0, q}, 32'h0);
        read_seg("R1 R7 rd ae lo", 18'h0007F);
        read_seg("R7 rd ae hi", 18'h00000);
        read_seg("R7 rd af lo", 18'h003F0);
        read_seg("R7 rd af hi", 18'h00000);
    endtask

    task automatic t_wide_load();
        write_seg(18'h3_1234);
        write_seg(18'h3_FF56);
        write_seg(18'h0_ABCD);
        write_seg(18'h0_009A);
        chk("R3 R9 ae wide", {8'd0, ae_ofs}, 32'h561234);
        chk("R3 af wide", {8'd0, af_ofs}, 32'h9AABCD);
        read_seg("R7 wide ae lo", 18'h01234);
        read_seg("R7 wide ae hi", 18'h00056);
        read_seg("R7 wide af lo", 18'h0ABCD);
        read_seg("R7 wide af hi", 18'h0009A);
    endtask

    task automatic t_hold();
        @(negedge clk_w);
        ld = 1'b0; wen = 1'b1; din = 18'h2_EEEE;
        repeat (3) @(negedge clk_w);
        ld = 1'b1; wen = 1'b0;
        repeat (3) @(negedge clk_w);
        ld = 1'b0;
        chk("R5 ae held", {8'd0, ae_ofs}, 32'h561234);
        chk("R5 af held", {8'd0, af_ofs}, 32'h9AABCD);
        @(negedge clk_r);
        ren = 1'b1;
        repeat (3) @(negedge clk_r);
        ren = 1'b0;
        chk("R7 q held", {14'd0, q}, 32'h0009A);
    endtask

    task automatic t_wrap();
        write_seg(18'h0_1111);
        chk("R6 wrap write", {8'd0, ae_ofs}, 32'h561111);
        read_seg("R6 R8 wrap read", 18'h01111);
        write_seg(18'h0_0077);
        chk("R8 write ptr own", {8'd0, ae_ofs}, 32'h771111);
        read_seg("R8 read ptr own", 18'h00077);
    endtask

    task automatic t_narrow();
        do_reset(1'b1);
        narrow = 1'b0;
        write_seg(18'h0_01AA);
        write_seg(18'h0_00BB);
        write_seg(18'h0_00CC);
        write_seg(18'h0_00DD);
        write_seg(18'h0_00EE);
        write_seg(18'h0_00FF);
        chk("R2 R4 R9 ae narrow", {8'd0, ae_ofs}, 32'hCCBBAA);
        chk("R4 af narrow", {8'd0, af_ofs}, 32'hFFEEDD);
        read_seg("R7 nar 0", 18'h000AA);
        read_seg("R7 nar 1", 18'h000BB);
        read_seg("R7 nar 2", 18'h000CC);
        read_seg("R7 nar 3", 18'h000DD);
        read_seg("R7 nar 4", 18'h000EE);
        read_seg("R7 nar 5", 18'h000FF);
        read_seg("R6 nar wrap", 18'h000AA);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_wide_load();
        t_hold();
        t_wrap();
        t_narrow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule